// File: doc/BRIEF.md
# Request-Paced Byte DMA Channel

This block is one DMA channel that copies bytes from a source location to a destination location. Either side can be memory, addressed in increasing or decreasing order or at a fixed address such as a memory-mapped I/O register, or it can be an I/O port. The channel does not move data on its own. It performs exactly one byte transfer for each request it accepts. Requests come from an external request pin, which is sensed by edge or by level, or from the ready flags of an on-chip serial port.

Software loads a source address, a destination address, a byte count and a mode word through a small register port. It then sets the enable bit. For every accepted request the channel runs one read cycle and then one write cycle on a simple synchronous single-byte bus. The bus returns read data in the same cycle. After the final byte the channel disables itself, latches a completion flag and can raise an interrupt. An optional end-of-transfer strobe marks the last write.

Top module: `dma_req_channel`

## Requirements
- R1: After a synchronous active-low reset the channel is disabled, the completion flag and interrupt enable are 0, `bus_req`, `eot_out` and `irq_out` are 0, and the control register reads 0.
- R2: A write to the control register (index 4) changes the enable bit (bit 0) only when bit 1 of the same write is 0. When bit 1 is 1 the enable bit keeps its value. Bit 2 of every control write loads the interrupt enable. A control read returns {done, irq enable, 0, enable} in bits 3..0.
- R3: An accepted request, taken only while the channel is idle and enabled, produces one read cycle at the source address (`bus_req`=1, `bus_wr`=0). The next cycle is a write cycle at the destination address (`bus_wr`=1) that carries the byte read. Then follows one idle cycle.
- R4: Side mode codes in the mode register (index 3, bits 1:0 source, bits 3:2 destination) are: 0 = memory, address +1 after each byte; 1 = memory, address −1; 2 = memory at a fixed address; 3 = I/O port at a fixed address, where `bus_io`=1 and only the low 16 address bits are driven, with the upper bits 0.
- R5: The count (index 2) decrements by one after each write cycle. The write that leaves the count at 0 clears the enable bit and sets the completion flag. A count of 0 at start means 65536 bytes, so one transfer leaves 0xFFFF with the channel still enabled.
- R6: When mode bit 6 is 1, `eot_out` is high for exactly the cycle of the final write. When mode bit 6 is 0, `eot_out` stays low.
- R7: `irq_out` is high while the completion flag and the interrupt enable are both 1. Writing a control word with bit 3 set clears the completion flag.
- R8: With mode bit 4 = 0 (level sense), transfers repeat every three cycles for as long as the request pin is high and count remains.
- R9: With mode bit 4 = 1 (edge sense), each rising edge of the request pin yields one transfer. A pin held high yields only one. An edge that arrives while a transfer is running is remembered and serviced as soon as the channel is idle.
- R10: The pin request is honoured only when bits 19, 17 and 16 of the checked address are all 0, and bit 18 does not matter. The checked address is the source address if the source side is I/O, otherwise the destination address.
- R11: With mode bit 5 = 1 (serial pacing) the request pin is ignored. The request is the transmit-empty flag when the destination side is I/O, and the receive-full flag otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 mode, 4 control |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` |
| xfer_req_in | input | 1 | External transfer request pin |
| ser_tx_empty | input | 1 | Serial port transmit-empty flag |
| ser_rx_full | input | 1 | Serial port receive-full flag |
| bus_req | output | 1 | Bus cycle active |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_io | output | 1 | Cycle targets I/O space |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| eot_out | output | 1 | End-of-transfer strobe |
| irq_out | output | 1 | Termination interrupt |

## Verification
The embedded properties watch on every cycle that a read cycle is always followed by a write carrying the byte just read. They also check that the count drops by one per write, that the final write disables the channel and flags completion, that a control write with bit 1 set leaves the enable bit alone, that the strobe appears only inside a write, and that I/O cycles never drive the upper address bits. Only the bench scenarios show the pacing: how many transfers a held level, a single edge, a held edge or an edge landing mid-transfer produce, that a request pin is blocked by the address condition, and that serial pacing picks the right flag and ignores the pin. The count-of-zero wrap is also shown there. Those scenarios compare a behavioural model against every output each cycle.

// File: rtl/dmac_pkg.sv
// Shared types for the request-paced DMA channel.
// Assumes: register indices and mode codes below are the software-visible contract.
package dmac_pkg;

    typedef enum logic [1:0] {
        SIDE_MEM_INC = 2'd0,
        SIDE_MEM_DEC = 2'd1,
        SIDE_MEM_FIX = 2'd2,
        SIDE_IO      = 2'd3
    } side_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       eot_sel;
        logic       serial_pace;
        logic       edge_sense;
        side_mode_e dst_mode;
        side_mode_e src_mode;
    } dmac_cfg_t;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_MODE = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_HOLD_BIT = 1;
    localparam int CTRL_IE_BIT   = 2;
    localparam int CTRL_DONE_BIT = 3;

endpackage

// File: rtl/dmac_regs.sv
// Register file of the channel: source/destination address, byte count,
// mode word and control/status. Addresses and count advance on the
// sequencer's step pulse; a CPU write to a register wins over that update.
// Assumes: step is a single-cycle pulse at the end of each write cycle.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              step,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output dmac_cfg_t         cfg,
    output logic              enable,
    output logic              done,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);
    localparam int               NSIDE    = 2;

    logic              irq_en;
    logic              finish;
    logic              ctrl_wr;
    logic [ADDR_W-1:0] side_q    [NSIDE];
    side_mode_e        side_mode [NSIDE];
    logic              unused_wdata;

    assign finish       = step && (cnt_q == CNT_LAST);
    assign ctrl_wr      = cpu_wr && (cpu_addr == REG_CTRL);
    assign side_mode[0] = cfg.src_mode;
    assign side_mode[1] = cfg.dst_mode;
    assign unused_wdata = ^cpu_wdata[REG_W-1:ADDR_W];

    // One address register per side, advanced according to its own mode.
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam logic [2:0] IDX = (s == 0) ? REG_SRC : REG_DST;
        logic [ADDR_W-1:0] addr_r;

        // Load from software, or step the address after each write cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_r <= '0;
            end else if (cpu_wr && cpu_addr == IDX) begin
                addr_r <= cpu_wdata[ADDR_W-1:0];
            end else if (step) begin
                case (side_mode[s])
                    SIDE_MEM_INC: addr_r <= addr_r + ADDR_W'(1);
                    SIDE_MEM_DEC: addr_r <= addr_r - ADDR_W'(1);
                    default:      addr_r <= addr_r;
                endcase
            end
        end

        assign side_q[s] = addr_r;
    end

    assign src_q = side_q[0];
    assign dst_q = side_q[1];

    // Byte count: loaded by software, decremented once per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cpu_wr && cpu_addr == REG_CNT) begin
            cnt_q <= cpu_wdata[CNT_W-1:0];
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Mode word holding side modes, request sensing and strobe select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cpu_wr && cpu_addr == REG_MODE) begin
            cfg.src_mode    <= side_mode_e'(cpu_wdata[1:0]);
            cfg.dst_mode    <= side_mode_e'(cpu_wdata[3:2]);
            cfg.edge_sense  <= cpu_wdata[4];
            cfg.serial_pace <= cpu_wdata[5];
            cfg.eot_sel     <= cpu_wdata[6];
        end
    end

    // Enable: written only with the hold bit clear, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (finish) begin
            enable <= 1'b0;
        end else if (ctrl_wr && !cpu_wdata[CTRL_HOLD_BIT]) begin
            enable <= cpu_wdata[CTRL_EN_BIT];
        end
    end

    // Interrupt enable follows every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en <= cpu_wdata[CTRL_IE_BIT];
        end
    end

    // Completion flag: set by the final byte, cleared by writing one to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (finish) begin
            done <= 1'b1;
        end else if (ctrl_wr && cpu_wdata[CTRL_DONE_BIT]) begin
            done <= 1'b0;
        end
    end

    assign irq = done & irq_en;

    // Read multiplexer for the register port.
    always_comb begin
        case (cpu_addr)
            REG_SRC:  cpu_rdata = REG_W'(src_q);
            REG_DST:  cpu_rdata = REG_W'(dst_q);
            REG_CNT:  cpu_rdata = REG_W'(cnt_q);
            REG_MODE: cpu_rdata = REG_W'(cfg);
            REG_CTRL: cpu_rdata = REG_W'({done, irq_en, 1'b0, enable});
            default:  cpu_rdata = '0;
        endcase
    end

    // R5: each write cycle lowers the count by exactly one.
    a_r5_count_step : assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(cpu_wr && cpu_addr == REG_CNT)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5: the last byte disables the channel and flags completion.
    a_r5_finish_stops : assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == CNT_LAST) |=> (!enable && done));

    // R2: a control write with the hold bit set leaves enable alone.
    a_r2_hold_keeps_enable : assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && cpu_wdata[CTRL_HOLD_BIT] && !finish) |=> (enable == $past(enable)));

endmodule

// File: rtl/dmac_req.sv
// Request qualification: external pin by edge or level, gated by the
// address condition, or serial-port flags. Remembers an edge seen while busy.
// Assumes: all request inputs are already synchronous to clk.
module dmac_req
    import dmac_pkg::*;
#(
    parameter int              ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] GATE_MASK = 20'hB0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              idle,
    input  side_mode_e        src_mode,
    input  side_mode_e        dst_mode,
    input  logic              edge_sense,
    input  logic              serial_pace,
    input  logic [ADDR_W-1:0] src_q,
    input  logic [ADDR_W-1:0] dst_q,
    input  logic              pin_req,
    input  logic              tx_empty,
    input  logic              rx_full,
    output logic              start
);

    logic              pin_prev;
    logic              pend;
    logic              rise;
    logic              addr_ok;
    logic              ser_req;
    logic              ext_req;
    logic              req_ok;
    logic [ADDR_W-1:0] chk_addr;

    assign rise     = pin_req & ~pin_prev;
    assign chk_addr = (src_mode == SIDE_IO) ? src_q : dst_q;
    assign addr_ok  = ((chk_addr & GATE_MASK) == '0);
    assign ser_req  = (dst_mode == SIDE_IO) ? tx_empty : rx_full;
    assign ext_req  = edge_sense ? (rise | pend) : pin_req;
    assign req_ok   = serial_pace ? ser_req : (ext_req & addr_ok);
    assign start    = idle & enable & req_ok;

    // Previous pin level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_req;
    end

    // Pending edge: kept until a transfer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!enable || !edge_sense || serial_pace) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend & ~start) | (rise & ~(start & ~pend));
        end
    end

    // R9: a remembered edge only exists in edge-sense pin mode.
    a_r9_pend_edge_mode : assert property (@(posedge clk) disable iff (!rst_n)
        (pend && start) |-> (edge_sense && !serial_pace));

endmodule

// File: rtl/dmac_seq.sv
// Transfer sequencer: idle -> read -> write -> idle per accepted request.
// Drives the bus master port and the end-of-transfer strobe.
// Assumes: bus_rdata is valid in the read cycle (zero wait states).
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int IO_ADDR_W = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  side_mode_e        src_mode,
    input  side_mode_e        dst_mode,
    input  logic              eot_sel,
    input  logic [ADDR_W-1:0] src_q,
    input  logic [ADDR_W-1:0] dst_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              idle,
    output logic              step,
    output logic              bus_req,
    output logic              bus_wr,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              eot
);

    seq_state_e        st;
    logic [DATA_W-1:0] data_q;

    function automatic logic [ADDR_W-1:0] eff_addr(input logic [ADDR_W-1:0] a,
                                                  input side_mode_e m);
        return (m == SIDE_IO) ? ADDR_W'(a[IO_ADDR_W-1:0]) : a;
    endfunction

    // State register of the read/write pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  st <= start ? ST_READ : ST_IDLE;
                ST_READ:  st <= ST_WRITE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Byte holding register, captured at the end of the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             data_q <= '0;
        else if (st == ST_READ) data_q <= bus_rdata;
    end

    assign idle = (st == ST_IDLE);
    assign step = (st == ST_WRITE);

    // Bus master outputs for the current cycle.
    always_comb begin
        bus_req   = (st != ST_IDLE);
        bus_wr    = (st == ST_WRITE);
        bus_io    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        if (st == ST_READ) begin
            bus_io   = (src_mode == SIDE_IO);
            bus_addr = eff_addr(src_q, src_mode);
        end else if (st == ST_WRITE) begin
            bus_io    = (dst_mode == SIDE_IO);
            bus_addr  = eff_addr(dst_q, dst_mode);
            bus_wdata = data_q;
        end
    end

    assign eot = eot_sel & step & (cnt_q == CNT_W'(1));

    // R3: a read cycle is always followed by a write cycle.
    a_r3_read_then_write : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr) |=> (bus_req && bus_wr));

    // R3: the write carries the byte returned in the preceding read.
    a_r3_write_data : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr) |-> (bus_wdata == $past(bus_rdata)));

    // R6: the strobe only appears during a write cycle.
    a_r6_eot_in_write : assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> (bus_req && bus_wr));

    // R4: I/O cycles never drive the upper address bits.
    a_r4_io_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_io) |-> (bus_addr[ADDR_W-1:IO_ADDR_W] == '0));

endmodule

// File: rtl/dma_req_channel.sv
// Top of the request-paced DMA channel: register file, request qualifier
// and transfer sequencer. One byte moves per accepted request.
// Assumes: single bus master, zero-wait synchronous bus.
module dma_req_channel
    import dmac_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter int                IO_ADDR_W = 16,
    parameter int                DATA_W    = 8,
    parameter int                CNT_W     = 16,
    parameter int                REG_W     = 32,
    parameter logic [ADDR_W-1:0] GATE_MASK = 20'hB0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    input  logic              xfer_req_in,
    input  logic              ser_tx_empty,
    input  logic              ser_rx_full,
    output logic              bus_req,
    output logic              bus_wr,
    output logic              bus_io,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              eot_out,
    output logic              irq_out
);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    dmac_cfg_t         cfg;
    logic              enable;
    logic              done;
    logic              idle;
    logic              step;
    logic              start;

    dmac_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .step      (step),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .cfg       (cfg),
        .enable    (enable),
        .done      (done),
        .irq       (irq_out)
    );

    dmac_req #(
        .ADDR_W    (ADDR_W),
        .GATE_MASK (GATE_MASK)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .idle        (idle),
        .src_mode    (cfg.src_mode),
        .dst_mode    (cfg.dst_mode),
        .edge_sense  (cfg.edge_sense),
        .serial_pace (cfg.serial_pace),
        .src_q       (src_q),
        .dst_q       (dst_q),
        .pin_req     (xfer_req_in),
        .tx_empty    (ser_tx_empty),
        .rx_full     (ser_rx_full),
        .start       (start)
    );

    dmac_seq #(
        .ADDR_W    (ADDR_W),
        .IO_ADDR_W (IO_ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_mode  (cfg.src_mode),
        .dst_mode  (cfg.dst_mode),
        .eot_sel   (cfg.eot_sel),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q),
        .bus_rdata (bus_rdata),
        .idle      (idle),
        .step      (step),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_io    (bus_io),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .eot       (eot_out)
    );

    // R7: the interrupt never shows without the completion flag.
    a_r7_irq_needs_done : assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> done);

endmodule

// File: tb/tb_dma_req_channel.sv
`timescale 1ns/1ps
module tb_dma_req_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_addr = 3'd4;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        xfer_req_in = 1'b0;
    logic        ser_tx_empty = 1'b0;
    logic        ser_rx_full = 1'b0;
    logic        bus_req, bus_wr, bus_io;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        eot_out, irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wr_seen = 0;
    int eot_seen = 0;
    logic [19:0] last_waddr = '0;
    logic        last_wio = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    dma_req_channel dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_req_in(xfer_req_in),
        .ser_tx_empty(ser_tx_empty), .ser_rx_full(ser_rx_full), .bus_req(bus_req),
        .bus_wr(bus_wr), .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eot_out(eot_out), .irq_out(irq_out)
    );

    // ---------------- behavioural reference model ----------------
    int          m_phase;      // 0 waiting, 1 reading, 2 writing
    logic [19:0] m_src, m_dst;
    int          m_cnt;        // 0..65535
    int          m_smode, m_dmode;
    bit          m_edge, m_serial, m_eotsel;
    bit          m_en, m_ie, m_done, m_pend, m_prev;
    logic [7:0]  m_byte;

    function automatic logic [19:0] eff(input logic [19:0] a, input int md);
        if (md == 3) return {4'h0, a[15:0]};
        return a;
    endfunction

    function automatic logic [19:0] adv(input logic [19:0] a, input int md);
        if (md == 0) return a + 20'd1;
        if (md == 1) return a - 20'd1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_src = '0; m_dst = '0; m_cnt = 0;
            m_smode = 0; m_dmode = 0; m_edge = 0; m_serial = 0; m_eotsel = 0;
            m_en = 0; m_ie = 0; m_done = 0; m_pend = 0; m_prev = 0; m_byte = '0;
        end else begin
            bit rise, aok, want, go, last, wctl;
            logic [19:0] gate_addr;
            rise = xfer_req_in && !m_prev;
            gate_addr = (m_smode == 3) ? m_src : m_dst;
            aok = (gate_addr[19] == 0) && (gate_addr[17] == 0) && (gate_addr[16] == 0);
            if (m_serial) want = (m_dmode == 3) ? ser_tx_empty : ser_rx_full;
            else if (m_edge) want = (rise || m_pend) && aok;
            else want = xfer_req_in && aok;
            go = (m_phase == 0) && m_en && want;
            last = (m_phase == 2) && (m_cnt == 1);
            wctl = cpu_wr && cpu_addr == 3'd4;
            // remembered edge
            if (!m_en || !m_edge || m_serial) m_pend = 0;
            else if (go && m_pend) m_pend = rise;
            else if (go) m_pend = 0;
            else if (rise) m_pend = 1;
            m_prev = xfer_req_in;
            // data capture and address/count progress
            if (m_phase == 1) m_byte = eff(m_src, m_smode) ^ 8'hA5;
            if (cpu_wr && cpu_addr == 3'd0) m_src = cpu_wdata[19:0];
            else if (m_phase == 2) m_src = adv(m_src, m_smode);
            if (cpu_wr && cpu_addr == 3'd1) m_dst = cpu_wdata[19:0];
            else if (m_phase == 2) m_dst = adv(m_dst, m_dmode);
            if (cpu_wr && cpu_addr == 3'd2) m_cnt = int'(cpu_wdata[15:0]);
            else if (m_phase == 2) m_cnt = (m_cnt + 65535) % 65536;
            if (cpu_wr && cpu_addr == 3'd3) begin
                m_smode = int'(cpu_wdata[1:0]); m_dmode = int'(cpu_wdata[3:2]);
                m_edge = cpu_wdata[4]; m_serial = cpu_wdata[5]; m_eotsel = cpu_wdata[6];
            end
            if (last) m_en = 0;
            else if (wctl && !cpu_wdata[1]) m_en = cpu_wdata[0];
            if (wctl) m_ie = cpu_wdata[2];
            if (last) m_done = 1;
            else if (wctl && cpu_wdata[3]) m_done = 0;
            case (m_phase)
                0: m_phase = go ? 1 : 0;
                1: m_phase = 2;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h at cycle %0d", what, got, exp, cycles);
        end
    endtask

    // Compare every output with the model, mid-cycle.
    always @(posedge clk) begin
        #2;
        cycles++;
        if (rst_n) begin
            logic [19:0] ea;
            logic [31:0] er;
            ea = (m_phase == 1) ? eff(m_src, m_smode) : (m_phase == 2) ? eff(m_dst, m_dmode) : 20'd0;
            chk(bus_req == (m_phase != 0), "R3 bus_req", 32'(bus_req), 32'(m_phase != 0));
            chk(bus_wr == (m_phase == 2), "R3 bus_wr", 32'(bus_wr), 32'(m_phase == 2));
            chk(bus_addr == ea, "R4 bus_addr", 32'(bus_addr), 32'(ea));
            chk(bus_io == ((m_phase == 1 && m_smode == 3) || (m_phase == 2 && m_dmode == 3)),
                "R4 bus_io", 32'(bus_io), 32'((m_phase == 1 && m_smode == 3) || (m_phase == 2 && m_dmode == 3)));
            chk(bus_wdata == ((m_phase == 2) ? m_byte : 8'h00), "R3 bus_wdata",
                32'(bus_wdata), 32'((m_phase == 2) ? m_byte : 8'h00));
            chk(eot_out == (m_eotsel && m_phase == 2 && m_cnt == 1), "R6 eot_out",
                32'(eot_out), 32'(m_eotsel && m_phase == 2 && m_cnt == 1));
            chk(irq_out == (m_done && m_ie), "R7 irq_out", 32'(irq_out), 32'(m_done && m_ie));
            case (cpu_addr)
                3'd0: er = 32'(m_src);
                3'd1: er = 32'(m_dst);
                3'd2: er = 32'(m_cnt);
                3'd3: er = {25'd0, m_eotsel, m_serial, m_edge, m_dmode[1:0], m_smode[1:0]};
                3'd4: er = {28'd0, m_done, m_ie, 1'b0, m_en};
                default: er = 32'd0;
            endcase
            chk(cpu_rdata == er, "R5 cpu_rdata", cpu_rdata, er);
            if (bus_req && bus_wr) begin
                wr_seen++; last_waddr = bus_addr; last_wio = bus_io;
            end
            if (eot_out) eot_seen++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = 3'd4;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string what);
        @(negedge clk);
        cpu_addr = a;
        @(posedge clk); #1;
        chk(cpu_rdata == exp, what, cpu_rdata, exp);
        @(negedge clk);
        cpu_addr = 3'd4;
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] md, input logic [19:0] s, input logic [19:0] d, input logic [15:0] n);
        wr_reg(3'd3, md);
        wr_reg(3'd0, 32'(s));
        wr_reg(3'd1, 32'(d));
        wr_reg(3'd2, 32'(n));
    endtask

    initial begin
        int w0;
        idle_n(3);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk(bus_req == 1'b0, "R1 bus idle", 32'(bus_req), 0);
        chk(irq_out == 1'b0 && eot_out == 1'b0, "R1 irq/eot low", 32'({irq_out, eot_out}), 0);
        chk(cpu_rdata == 32'd0, "R1 control reads 0", cpu_rdata, 0);

        // R2: enable guarded by the hold bit
        wr_reg(3'd4, 32'h3);
        rd_chk(3'd4, 32'h0, "R2 hold bit blocks enable");
        wr_reg(3'd4, 32'h1);
        rd_chk(3'd4, 32'h1, "R2 enable set");
        wr_reg(3'd4, 32'h0);

        // R8 level sense, memory increment both sides, strobe on
        setup(32'h40, 20'h01000, 20'h02000, 16'd3);
        xfer_req_in = 1'b1;
        w0 = wr_seen;
        wr_reg(3'd4, 32'h5);
        idle_n(20);
        chk(wr_seen - w0 == 3, "R8 level transfers", 32'(wr_seen - w0), 3);
        chk(eot_seen == 1, "R6 one strobe", 32'(eot_seen), 1);
        chk(irq_out == 1'b1, "R7 irq raised", 32'(irq_out), 1);
        rd_chk(3'd4, 32'hC, "R5 auto disable and done");
        rd_chk(3'd0, 32'h01003, "R4 source incremented");
        xfer_req_in = 1'b0;
        wr_reg(3'd4, 32'hA);
        rd_chk(3'd4, 32'h0, "R7 done cleared");

        // R4 decrement source into I/O destination; bit 18 ignored (R10)
        setup(32'h0D, 20'h00010, 20'h41234, 16'd2);
        xfer_req_in = 1'b1;
        w0 = wr_seen;
        wr_reg(3'd4, 32'h1);
        idle_n(15);
        chk(wr_seen - w0 == 2, "R10 bit 18 ignored", 32'(wr_seen - w0), 2);
        chk(last_waddr == 20'h01234 && last_wio, "R4 I/O address", 32'(last_waddr), 32'h01234);
        rd_chk(3'd0, 32'h0000E, "R4 source decremented");
        xfer_req_in = 1'b0;
        wr_reg(3'd4, 32'hA);

        // R10 gate blocks when bit 16 is set
        setup(32'h0D, 20'h00010, 20'h11234, 16'd4);
        xfer_req_in = 1'b1;
        w0 = wr_seen;
        wr_reg(3'd4, 32'h1);
        idle_n(20);
        chk(wr_seen - w0 == 0, "R10 gated request", 32'(wr_seen - w0), 0);
        rd_chk(3'd2, 32'd4, "R10 count untouched");
        wr_reg(3'd4, 32'h0);
        xfer_req_in = 1'b0;

        // R9 edge sense, fixed source
        setup(32'h12, 20'h00300, 20'h00400, 16'd10);
        w0 = wr_seen;
        wr_reg(3'd4, 32'h1);
        @(negedge clk); xfer_req_in = 1'b1;
        @(negedge clk); xfer_req_in = 1'b0;
        idle_n(8);
        chk(wr_seen - w0 == 1, "R9 single pulse", 32'(wr_seen - w0), 1);
        w0 = wr_seen;
        xfer_req_in = 1'b1; idle_n(10); xfer_req_in = 1'b0;
        idle_n(8);
        chk(wr_seen - w0 == 1, "R9 held pin one transfer", 32'(wr_seen - w0), 1);
        w0 = wr_seen;
        xfer_req_in = 1'b1; @(negedge clk);
        xfer_req_in = 1'b0; @(negedge clk);
        xfer_req_in = 1'b1; @(negedge clk);
        xfer_req_in = 1'b0;
        idle_n(10);
        chk(wr_seen - w0 == 2, "R9 edge during transfer kept", 32'(wr_seen - w0), 2);
        rd_chk(3'd2, 32'd6, "R5 count after four");
        rd_chk(3'd1, 32'h00404, "R4 destination incremented");
        wr_reg(3'd4, 32'h0);

        // R11 serial pacing
        setup(32'h2C, 20'h00500, 20'h00020, 16'd8);
        xfer_req_in = 1'b1; ser_rx_full = 1'b1;
        w0 = wr_seen;
        wr_reg(3'd4, 32'h1);
        idle_n(10);
        chk(wr_seen - w0 == 0, "R11 pin and rx ignored", 32'(wr_seen - w0), 0);
        ser_rx_full = 1'b0; ser_tx_empty = 1'b1;
        idle_n(9);
        ser_tx_empty = 1'b0;
        idle_n(4);
        chk(wr_seen - w0 == 3, "R11 tx empty paces", 32'(wr_seen - w0), 3);
        wr_reg(3'd3, 32'h23);
        w0 = wr_seen;
        ser_rx_full = 1'b1;
        idle_n(12);
        ser_rx_full = 1'b0;
        idle_n(4);
        chk(wr_seen - w0 == 4, "R11 rx full paces", 32'(wr_seen - w0), 4);
        rd_chk(3'd2, 32'd1, "R11 count left");
        xfer_req_in = 1'b0;
        wr_reg(3'd4, 32'h0);

        // R5 zero count means 65536
        setup(32'h10, 20'h00700, 20'h00800, 16'd0);
        w0 = wr_seen;
        wr_reg(3'd4, 32'h1);
        @(negedge clk); xfer_req_in = 1'b1;
        @(negedge clk); xfer_req_in = 1'b0;
        idle_n(8);
        chk(wr_seen - w0 == 1, "R5 one byte of zero count", 32'(wr_seen - w0), 1);
        rd_chk(3'd2, 32'h0FFFF, "R5 count wraps");
        rd_chk(3'd4, 32'h1, "R5 still enabled");
        wr_reg(3'd4, 32'h0);

        // R6 strobe disabled
        setup(32'h00, 20'h00900, 20'h00A00, 16'd1);
        xfer_req_in = 1'b1;
        w0 = eot_seen;
        wr_reg(3'd4, 32'h1);
        idle_n(8);
        xfer_req_in = 1'b0;
        chk(eot_seen - w0 == 0, "R6 no strobe when deselected", 32'(eot_seen - w0), 0);
        rd_chk(3'd4, 32'h8, "R5 done after single byte");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule